// File: doc/BRIEF.md
# Serial Control-Word Loader

This block takes a three-wire serial programming stream made of a data line, a serial clock and a load strobe, and turns it into the static control fields of a frequency-synthesis datapath. All three wires are treated as asynchronous. Each one passes through a synchronizer into the block's own clock domain. On every rising edge of the serial clock, one data bit enters a 19-bit shift register from its least significant end, so the word is sent most significant bit first.

A rising load strobe starts one transfer. The bit that was shifted in last (bit 0) picks the destination:

- When bit 0 is high, the word is a reference word. It carries the 14-bit reference ratio and three single-bit controls: prescaler select, phase polarity and monitor select.
- When bit 0 is low, the word is a divider word. It carries the 7-bit swallow value and the 11-bit main-counter value.

The register that is not selected keeps its value. A reference ratio below 5 is not allowed, but it is still stored, and an error flag reports it. Serial loading does not depend on any power mode of the surrounding datapath.

A three-state load sequencer carries out the transfer:

- **LD_IDLE**: the sequencer waits for the synchronized strobe to go high. That transition is *arm*, and it leads to LD_COMMIT.
- **LD_COMMIT**: this state lasts one cycle and performs the transfer. It always moves on to LD_HOLD (the *commit* transition).
- **LD_HOLD**: the sequencer waits for the strobe to go low. That transition is *release*, and it leads back to LD_IDLE.

Top module: `ctlword_loader`

## Requirements
- R1: After reset, every output field is zero and `ratio_err` is low.
- R2: A data bit is captured only on a rising edge of `ser_clk` and enters at bit 0 of the shift register, while older bits move one place up, so the word is sent MSB first. Only the last 18 bits (reference word) or 19 bits (divider word) matter, and earlier bits are ignored.
- R3: If bit 0 is 1 at the load, the reference fields are updated from these bits: `ref_ratio` from bits 14..1, `presc_sel` from bit 15, `phase_pol` from bit 16 and `mon_sel` from bit 17. `swallow` and `main_cnt` keep their values.
- R4: If bit 0 is 0 at the load, the divider fields are updated from these bits: `swallow` from bits 7..1 and `main_cnt` from bits 18..8. All reference fields and `ratio_err` keep their values.
- R5: Each rising edge of `ser_load` causes exactly one transfer. While `ser_load` stays high, shifting more bits does not change any output.
- R6: A reference load with a ratio below 5 still stores that ratio and sets `ratio_err`. A reference load with a ratio of 5 or more clears it. The full range up to 16383 is accepted.
- R7: Shifting bits with no load strobe does not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe, active on its rising edge |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_sel | output | 1 | Prescaler modulus select |
| phase_pol | output | 1 | Phase comparator polarity |
| mon_sel | output | 1 | Monitor output select |
| swallow | output | 7 | Swallow counter value |
| main_cnt | output | 11 | Main counter value |
| ratio_err | output | 1 | Last reference ratio was below the minimum |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, field widths of 14, 7 and 11, and a minimum ratio of 5. With these values the ratio boundary (4 against 5) and the all-ones ratio of 16383 are reachable, and so is a 19-bit stream that carries a leading junk bit ahead of an 18-bit reference word. The serial clock runs at one eighth of the block clock, so each synchronized edge is distinct. Strobes are held high for long stretches, with shifting in between, to test the single-transfer rule.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;
    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_COMMIT = 2'd1,
        LD_HOLD   = 2'd2
    } ld_state_e;
endpackage

// File: rtl/ctlword_sync.sv
module ctlword_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;

    // R2: a rise is a single-cycle event
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ctlword_shreg.sv
module ctlword_shreg #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end

    // R2: new bit lands at the bottom, older bits move up
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0])));
    // R2: no shift, no change
    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/ctlword_seq.sv
module ctlword_seq
    import ctlword_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_lvl,
    output logic commit
);
    ld_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE:   if (load_lvl)  nxt = LD_COMMIT;  // arm
            LD_COMMIT:                nxt = LD_HOLD;    // commit
            LD_HOLD:   if (!load_lvl) nxt = LD_IDLE;    // release
            default:                  nxt = LD_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            LD_COMMIT: commit = 1'b1;
            default:   commit = 1'b0;
        endcase
    end

    // R5: one transfer per strobe
    p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R5: a strobe held high never re-arms
    p_hold_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LD_HOLD && load_lvl) |=> !commit);
endmodule

// File: rtl/ctlword_regs.sv
module ctlword_regs #(
    parameter int REF_W   = 14,
    parameter int SWL_W   = 7,
    parameter int MAIN_W  = 11,
    parameter int MIN_REF = 5,
    localparam int SR_W   = 1 + SWL_W + MAIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [SR_W-1:0]   word,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_sel,
    output logic              phase_pol,
    output logic              mon_sel,
    output logic [SWL_W-1:0]  swallow,
    output logic [MAIN_W-1:0] main_cnt,
    output logic              ratio_err
);
    localparam int PRE_B = REF_W + 1;
    localparam int POL_B = REF_W + 2;
    localparam int MON_B = REF_W + 3;

    logic ref_sel;
    logic ref_ld, div_ld;
    logic [REF_W-1:0] new_ratio;

    assign ref_sel   = word[0];
    assign ref_ld    = commit & ref_sel;
    assign div_ld    = commit & ~ref_sel;
    assign new_ratio = word[REF_W:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ratio <= '0;
            presc_sel <= 1'b0;
            phase_pol <= 1'b0;
            mon_sel   <= 1'b0;
            ratio_err <= 1'b0;
        end else if (ref_ld) begin
            ref_ratio <= new_ratio;
            presc_sel <= word[PRE_B];
            phase_pol <= word[POL_B];
            mon_sel   <= word[MON_B];
            ratio_err <= (32'(new_ratio) < MIN_REF);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swallow  <= '0;
            main_cnt <= '0;
        end else if (div_ld) begin
            swallow  <= word[SWL_W:1];
            main_cnt <= word[SR_W-1:SWL_W+1];
        end
    end

    // R3: reference load leaves the divider fields alone
    p_div_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ld |=> $stable(swallow) && $stable(main_cnt));
    // R4: divider load leaves the reference fields and flag alone
    p_ref_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_ld |=> $stable(ref_ratio) && $stable(ratio_err) && $stable(presc_sel));
    // R6: flag reflects the ratio just stored
    p_err_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ld |=> ratio_err == (32'(ref_ratio) < MIN_REF));
    // R7: without a transfer, nothing changes
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ref_ratio) && $stable(swallow) && $stable(main_cnt) && $stable(ratio_err));
endmodule

// File: rtl/ctlword_loader.sv
module ctlword_loader
    import ctlword_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_W       = 14,
    parameter int SWL_W       = 7,
    parameter int MAIN_W      = 11,
    parameter int MIN_REF     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_sel,
    output logic              phase_pol,
    output logic              mon_sel,
    output logic [SWL_W-1:0]  swallow,
    output logic [MAIN_W-1:0] main_cnt,
    output logic              ratio_err
);
    localparam int SR_W = 1 + SWL_W + MAIN_W;

    logic sclk_lvl, sclk_rise;
    logic sdat_lvl, sdat_rise;
    logic load_lvl, load_rise;
    logic commit;
    logic [SR_W-1:0] word;

    ctlword_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .din(ser_clk),  .level(sclk_lvl), .rise(sclk_rise));
    ctlword_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .din(ser_data), .level(sdat_lvl), .rise(sdat_rise));
    ctlword_sync #(.STAGES(SYNC_STAGES)) u_sync_ld (
        .clk(clk), .rst_n(rst_n), .din(ser_load), .level(load_lvl), .rise(load_rise));

    ctlword_shreg #(.W(SR_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .din(sdat_lvl), .word(word));

    ctlword_seq u_seq (
        .clk(clk), .rst_n(rst_n), .load_lvl(load_lvl), .commit(commit));

    ctlword_regs #(
        .REF_W(REF_W), .SWL_W(SWL_W), .MAIN_W(MAIN_W), .MIN_REF(MIN_REF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
        .ref_ratio(ref_ratio), .presc_sel(presc_sel), .phase_pol(phase_pol),
        .mon_sel(mon_sel), .swallow(swallow), .main_cnt(main_cnt),
        .ratio_err(ratio_err));

    logic unused_ok;
    assign unused_ok = sclk_lvl ^ sdat_rise;

    // R5: a transfer follows a strobe rise
    p_commit_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(load_rise));
endmodule

// File: tb/ctlword_loader_test.sv
module ctlword_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [13:0] ref_ratio;
    logic presc_sel, phase_pol, mon_sel, ratio_err;
    logic [6:0]  swallow;
    logic [10:0] main_cnt;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ctlword_loader uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .ref_ratio(ref_ratio), .presc_sel(presc_sel),
        .phase_pol(phase_pol), .mon_sel(mon_sel), .swallow(swallow),
        .main_cnt(main_cnt), .ratio_err(ratio_err));

    task automatic chk(input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d", what, got, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [18:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            wclk(4);
            ser_clk = 1'b1;
            wclk(4);
            ser_clk = 1'b0;
        end
        wclk(4);
    endtask

    task automatic strobe();
        ser_load = 1'b1;
        wclk(6);
        ser_load = 1'b0;
        wclk(8);
    endtask

    function automatic logic [18:0] ref_word(input logic [13:0] r, input logic p,
                                             input logic f, input logic m);
        return {1'b0, m, f, p, r, 1'b1};
    endfunction

    function automatic logic [18:0] div_word(input logic [10:0] n, input logic [6:0] a);
        return {n, a, 1'b0};
    endfunction

    task automatic t_reset();
        chk("R1 ref_ratio", ref_ratio, 0);
        chk("R1 swallow", swallow, 0);
        chk("R1 main_cnt", main_cnt, 0);
        chk("R1 ctl bits", {presc_sel, phase_pol, mon_sel}, 0);
        chk("R1 ratio_err", ratio_err, 0);
    endtask

    task automatic t_ref_load();
        send_bits(ref_word(14'd1234, 1'b1, 1'b0, 1'b1), 18);
        strobe();
        chk("R3 ref_ratio", ref_ratio, 1234);
        chk("R3 presc_sel", presc_sel, 1);
        chk("R3 phase_pol", phase_pol, 0);
        chk("R3 mon_sel", mon_sel, 1);
        chk("R3 divider untouched", {main_cnt, swallow}, 0);
        chk("R6 err low for legal ratio", ratio_err, 0);
    endtask

    task automatic t_div_load();
        send_bits(div_word(11'd1500, 7'd93), 19);
        strobe();
        chk("R4 swallow", swallow, 93);
        chk("R4 main_cnt", main_cnt, 1500);
        chk("R4 ref untouched", ref_ratio, 1234);
        chk("R4 ctl untouched", {presc_sel, phase_pol, mon_sel}, 3'b101);
    endtask

    task automatic t_leading_junk();
        // R2: an extra leading 1 is shifted out of the reference word
        send_bits({1'b1, 18'(ref_word(14'd777, 1'b0, 1'b1, 1'b0))}, 19);
        strobe();
        chk("R2 ratio after junk bit", ref_ratio, 777);
        chk("R2 ctl after junk bit", {presc_sel, phase_pol, mon_sel}, 3'b010);
    endtask

    task automatic t_no_load();
        send_bits(div_word(11'd5, 7'd1), 19);
        wclk(10);
        chk("R7 swallow kept", swallow, 93);
        chk("R7 main kept", main_cnt, 1500);
    endtask

    task automatic t_hold_high();
        send_bits(div_word(11'd2047, 7'd127), 19);
        ser_load = 1'b1;
        wclk(10);
        chk("R5 first transfer swallow", swallow, 127);
        chk("R5 first transfer main", main_cnt, 2047);
        send_bits(div_word(11'd300, 7'd4), 19);
        wclk(6);
        chk("R5 no reload while high", main_cnt, 2047);
        ser_load = 1'b0;
        wclk(8);
        chk("R5 no reload on fall", swallow, 127);
        strobe();
        chk("R5 next rise loads", main_cnt, 300);
    endtask

    task automatic t_ratio_err();
        send_bits(ref_word(14'd4, 1'b0, 1'b0, 1'b0), 18);
        strobe();
        chk("R6 ratio 4 stored", ref_ratio, 4);
        chk("R6 ratio 4 flagged", ratio_err, 1);
        send_bits(div_word(11'd9, 7'd2), 19);
        strobe();
        chk("R6 flag kept over divider load", ratio_err, 1);
        send_bits(ref_word(14'd5, 1'b0, 1'b0, 1'b0), 18);
        strobe();
        chk("R6 ratio 5 clears", ratio_err, 0);
        send_bits(ref_word(14'd16383, 1'b1, 1'b1, 1'b1), 18);
        strobe();
        chk("R6 ratio max", ref_ratio, 16383);
        chk("R6 ratio max no flag", ratio_err, 0);
    endtask

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(3);
        t_reset();
        t_ref_load();
        t_div_load();
        t_leading_junk();
        t_no_load();
        t_hold_high();
        t_ratio_err();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule